// File: doc/BRIEF.md
# Reset-Time Strap Configuration Sampler

After every reset release this block reads board straps from pins that later serve as port indicator outputs and as power-enable outputs. For a fixed number of clock cycles it keeps all of those pins tri-stated, with pull-ups enabled on the strap pins. This lets an open pin settle high while a grounded pin reads low. On the last cycle of that window it latches three decoded settings: how many downstream ports are usable, which ports carry a non-removable device, and how port power is switched.

Once the window ends, the block raises a done flag. It releases the pull-ups and turns on the power-enable drivers, which are open-drain. It also enables only the indicator outputs that belong to usable, removable ports. Indicator pin 1 is the exception: it stays enabled in every configuration because it also serves as a serial clock. The pins pass through a synchronizer before they are decoded. The latched settings stay fixed until the next reset, and each reset starts a fresh window.

Pin vectors are indexed from zero: bit i of an LED or power pin vector belongs to downstream port i+1.

Top module: `strap_sampler`

## Requirements
- R1: `done_o` is 0 during reset and becomes 1 exactly WINDOW_CYCLES clock edges after reset is released. It then stays 1 until the next reset.
- R2: While `done_o` is 0, all bits of `led_oe_o` and `pwr_oe_o` are 0. In the same period `led_pu_o` is 7'b110_1110 (LED pins 7, 6, 4, 3, 2) and `pwr_pu_o` is 7'b110_0000 (power pins 7, 6).
- R3: `port_count_o` is decoded from the pair (LED7 = bit 6, LED6 = bit 5), where a grounded pin reads 0. The codes map as 00→4, 10→5, 01→6 and 11→7.
- R4: `fixed_map_o` has bit N set when port N is non-removable, and bit 0 is always 0. The 3-bit code is formed from LED4, LED3 and LED2 (bits 3, 2, 1), with a grounded pin reading 1. The codes map as 0→none, 1→port 2, 2→ports 3 and 2, and 3 to 7→ports 1 through the code value.
- R5: `pwr_mode_o` takes 0 for individual switching, 1 for multi-gang and 2 for fully ganged. PWR7 (bit 6) low with PWR6 (bit 5) high selects 1. Both low selects 2. Both high, or PWR7 high with PWR6 low, selects 0.
- R6: Once `done_o` is 1, both pull-up vectors are 0 and `pwr_oe_o` is all ones.
- R7: Once `done_o` is 1, `led_oe_o[i]` is 1 exactly when port i+1 is within the port count and is not non-removable. Bit 0 is always 1.
- R8: Pin changes made after `done_o` rises leave every output unchanged until the next reset.
- R9: A reset asserted in the middle of the window restarts the window. Any later reset samples the pins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| led_pin_i | input | 7 | Raw levels of indicator pins, bit i = port i+1 |
| pwr_pin_i | input | 7 | Raw levels of power-enable pins, bit i = port i+1 |
| port_count_o | output | 3 | Usable downstream port count |
| fixed_map_o | output | 8 | Non-removable bitmap, bit N = port N |
| pwr_mode_o | output | 2 | Power switching mode |
| led_oe_o | output | 7 | Indicator output-driver enables |
| led_pu_o | output | 7 | Indicator pin pull-up enables |
| pwr_oe_o | output | 7 | Power-enable open-drain driver enables |
| pwr_pu_o | output | 7 | Power-enable pin pull-up enables |
| done_o | output | 1 | Sampling complete |

## Verification
The bench builds the block with a six-cycle window and a two-stage synchronizer. With these values a whole window plus its aftermath fits in a dozen cycles, so every strap code of each field can be swept. Because the window is only a few cycles longer than the synchronizer depth, a wrong capture cycle or a wrong synchronizer alignment shows up immediately in the first cycle where `done_o` is checked. The short window also makes it cheap to assert reset in the middle of a window and to change pins after capture.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NPORT = 7;
  localparam int MAPW  = NPORT + 1;
  localparam int CNTW  = 3;

  localparam logic [NPORT-1:0] LED_STRAP_MASK = 7'b110_1110;
  localparam logic [NPORT-1:0] PWR_STRAP_MASK = 7'b110_0000;

  typedef enum logic [1:0] {
    PWR_INDIV  = 2'd0,
    PWR_MGANG  = 2'd1,
    PWR_GANGED = 2'd2
  } pwr_mode_e;

  typedef struct packed {
    logic [CNTW-1:0] count;
    logic [MAPW-1:0] fixed_map;
    pwr_mode_e       mode;
  } strap_cfg_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '1;
          else     stage_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
  parameter int WINDOW_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic capture_o,
  output logic done_o
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign capture_o = !done_q && (cnt_q == CW'(WINDOW_CYCLES - 1));
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (capture_o) done_q <= 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> (cnt_q < CW'(WINDOW_CYCLES))); // R1
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic [NPORT-1:0] led_i,
  input  logic [NPORT-1:0] pwr_i,
  output strap_cfg_t       cfg_o
);
  logic [2:0] fix_code;

  always_comb begin
    // port count: {LED6, LED7} as a binary offset above four
    cfg_o.count = CNTW'(4) + CNTW'({led_i[5], led_i[6]});

    // grounded pin reads as a one
    fix_code = ~{led_i[3], led_i[2], led_i[1]};
    cfg_o.fixed_map = '0;
    for (int p = 1; p < MAPW; p++) begin
      case (fix_code)
        3'd0:    cfg_o.fixed_map[p] = 1'b0;
        3'd1:    cfg_o.fixed_map[p] = (p == 2);
        3'd2:    cfg_o.fixed_map[p] = (p == 2) || (p == 3);
        default: cfg_o.fixed_map[p] = (p <= int'(fix_code));
      endcase
    end

    if (!pwr_i[6] && pwr_i[5])       cfg_o.mode = PWR_MGANG;
    else if (!pwr_i[6] && !pwr_i[5]) cfg_o.mode = PWR_GANGED;
    else                             cfg_o.mode = PWR_INDIV;
  end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] led_pin_i,
  input  logic [6:0] pwr_pin_i,
  output logic [2:0] port_count_o,
  output logic [7:0] fixed_map_o,
  output logic [1:0] pwr_mode_o,
  output logic [6:0] led_oe_o,
  output logic [6:0] led_pu_o,
  output logic [6:0] pwr_oe_o,
  output logic [6:0] pwr_pu_o,
  output logic       done_o
);
  logic [NPORT-1:0] led_s, pwr_s;
  logic             capture, done;
  strap_cfg_t       dec_cfg, cfg_q;
  logic [NPORT-1:0] led_en_mask;
  logic [NPORT-1:0] led_oe_q, led_pu_q, pwr_oe_q, pwr_pu_q;

  strap_sync #(.WIDTH(NPORT), .STAGES(SYNC_STAGES)) u_sync_led (
    .clk(clk), .rst(rst), .d_i(led_pin_i), .q_o(led_s));
  strap_sync #(.WIDTH(NPORT), .STAGES(SYNC_STAGES)) u_sync_pwr (
    .clk(clk), .rst(rst), .d_i(pwr_pin_i), .q_o(pwr_s));

  strap_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .capture_o(capture), .done_o(done));

  strap_decode u_decode (.led_i(led_s), .pwr_i(pwr_s), .cfg_o(dec_cfg));

  // indicator enable: port usable and removable; port 1 keeps its clock role
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      led_en_mask[i] = ((i + 1) <= int'(dec_cfg.count)) && !dec_cfg.fixed_map[i+1];
    end
    led_en_mask[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      led_oe_q <= '0;
      pwr_oe_q <= '0;
      led_pu_q <= LED_STRAP_MASK;
      pwr_pu_q <= PWR_STRAP_MASK;
    end else if (capture) begin
      cfg_q    <= dec_cfg;
      led_oe_q <= led_en_mask;
      pwr_oe_q <= '1;
      led_pu_q <= '0;
      pwr_pu_q <= '0;
    end
  end

  assign port_count_o = cfg_q.count;
  assign fixed_map_o  = cfg_q.fixed_map;
  assign pwr_mode_o   = cfg_q.mode;
  assign led_oe_o     = led_oe_q;
  assign led_pu_o     = led_pu_q;
  assign pwr_oe_o     = pwr_oe_q;
  assign pwr_pu_o     = pwr_pu_q;
  assign done_o       = done;

  AST_WINDOW_HIGHZ: assert property (@(posedge clk) disable iff (rst)
    !done |-> (led_oe_q == '0) && (pwr_oe_q == '0)); // R2
  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (cfg_q.count >= 3'd4)); // R3
  AST_MAP_BIT0: assert property (@(posedge clk) disable iff (rst)
    done |-> !cfg_q.fixed_map[0]); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (pwr_mode_o != 2'd3)); // R5
  AST_PULLUPS_OFF: assert property (@(posedge clk) disable iff (rst)
    done |-> (led_pu_q == '0) && (pwr_pu_q == '0)); // R6
  AST_SCL_KEPT: assert property (@(posedge clk) disable iff (rst)
    done |-> led_oe_q[0]); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> ($stable(cfg_q) && $stable(led_oe_q))); // R8
endmodule

// File: tb/strap_sampler_tb_top.sv
module strap_sampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 6;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] led_pin = 7'h7F, pwr_pin = 7'h7F;
  logic [6:0] snap_led = 7'h7F, snap_pwr = 7'h7F;
  logic [2:0] port_count;
  logic [7:0] fixed_map;
  logic [1:0] pwr_mode;
  logic [6:0] led_oe, led_pu, pwr_oe, pwr_pu;
  logic       done;
  int cyc = 0;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else if (cyc < 100000) cyc <= cyc + 1;
  end

  strap_sampler #(.WINDOW_CYCLES(WIN), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .led_pin_i(led_pin), .pwr_pin_i(pwr_pin),
    .port_count_o(port_count), .fixed_map_o(fixed_map), .pwr_mode_o(pwr_mode),
    .led_oe_o(led_oe), .led_pu_o(led_pu), .pwr_oe_o(pwr_oe), .pwr_pu_o(pwr_pu),
    .done_o(done));

  function automatic int m_count(logic [6:0] l);
    case ({l[6], l[5]})
      2'b00:   return 4;
      2'b10:   return 5;
      2'b01:   return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] m_map(logic [6:0] l);
    case ({~l[3], ~l[2], ~l[1]})
      3'd0: return 8'h00;
      3'd1: return 8'h04;
      3'd2: return 8'h0C;
      3'd3: return 8'h0E;
      3'd4: return 8'h1E;
      3'd5: return 8'h3E;
      3'd6: return 8'h7E;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic int m_mode(logic [6:0] p);
    case ({p[6], p[5]})
      2'b01:   return 1;
      2'b00:   return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [6:0] m_oe(logic [6:0] l);
    logic [6:0] r;
    logic [7:0] mp;
    mp = m_map(l);
    for (int port = 1; port <= 7; port++)
      r[port-1] = (port <= m_count(l)) && !mp[port];
    r[0] = 1'b1;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_now();
    bit exp_done;
    exp_done = (cyc >= WIN);
    check(done == exp_done, "R1 done", 32'(done), 32'(exp_done));
    if (!exp_done) begin
      check(led_oe == 7'h00 && pwr_oe == 7'h00, "R2 oe", {led_oe, 8'h0, pwr_oe}, 0);
      check(led_pu == 7'b110_1110 && pwr_pu == 7'b110_0000, "R2 pu",
            {led_pu, 8'h0, pwr_pu}, {7'b110_1110, 8'h0, 7'b110_0000});
    end else begin
      check(32'(port_count) == m_count(snap_led), "R3 count", 32'(port_count), m_count(snap_led));
      check(fixed_map == m_map(snap_led), "R4 map", 32'(fixed_map), 32'(m_map(snap_led)));
      check(32'(pwr_mode) == m_mode(snap_pwr), "R5 mode", 32'(pwr_mode), m_mode(snap_pwr));
      check(led_pu == 0 && pwr_pu == 0 && pwr_oe == 7'h7F, "R6 release",
            {led_pu, 8'h0, pwr_pu, 1'b0, pwr_oe}, {23'h0, 7'h7F});
      check(led_oe == m_oe(snap_led), "R7 led_oe", 32'(led_oe), 32'(m_oe(snap_led)));
    end
  endtask

  task automatic run_window(input logic [6:0] l, input logic [6:0] p, input int n);
    @(negedge clk);
    rst = 1'b1;
    led_pin = l; pwr_pin = p; snap_led = l; snap_pwr = p;
    @(negedge clk);
    compare_reset();
    rst = 1'b0;
    repeat (n) begin
      @(negedge clk);
      compare_now();
    end
  endtask

  task automatic compare_reset();
    check(done == 1'b0 && led_oe == 0 && pwr_oe == 0, "R1 reset state",
          {done, led_oe, pwr_oe}, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // all open: 7 ports, none fixed, individual
    run_window(7'h7F, 7'h7F, WIN + 3);
    // count codes (R3) with several fixed-map codes (R4) and modes (R5)
    run_window(7'b001_0110, 7'b011_1111, WIN + 3);
    run_window(7'b100_0100, 7'b001_1111, WIN + 3);
    run_window(7'b010_1010, 7'b101_1111, WIN + 3);
    run_window(7'b110_1100, 7'h7F, WIN + 3);
    for (int c = 0; c < 8; c++) begin
      logic [6:0] l;
      l = 7'h7F;
      l[3:1] = ~3'(c);
      run_window(l, 7'(7'h7F ^ 7'(c << 5)), WIN + 2);
    end
    // R8: pin changes after capture have no effect
    run_window(7'b101_1010, 7'b011_1111, WIN + 1);
    led_pin = ~led_pin; pwr_pin = 7'h00;
    repeat (8) begin
      @(negedge clk);
      check(32'(port_count) == m_count(snap_led) && fixed_map == m_map(snap_led) &&
            32'(pwr_mode) == m_mode(snap_pwr) && led_oe == m_oe(snap_led),
            "R8 frozen", {port_count, fixed_map, pwr_mode, led_oe},
            {3'(m_count(snap_led)), m_map(snap_led), 2'(m_mode(snap_pwr)), m_oe(snap_led)});
    end
    // R9: reset in the middle of a window restarts it with new straps
    run_window(7'h00, 7'h00, 3);
    run_window(7'b010_0110, 7'b011_1111, WIN + 3);
    check(done == 1'b1 && 32'(port_count) == 6, "R9 resample", {done, port_count}, {1'b1, 3'd6});
    finish_run();
  end
endmodule